// File: doc/BRIEF.md
# Sign-Aware Significand Rounder

This block shortens a sign-magnitude fraction by three low-order bits and rounds the kept part under one of four modes. The three dropped bits act as guard, round and sticky positions. The rounder combines the operand's sign with the selected mode. A directed mode therefore raises the magnitude only when it points away from zero for that sign.

A floating-point datapath uses it after alignment or an arithmetic step. Each input set is captured on a clock edge, and the rounded fraction, an overflow carry and an inexact flag appear on registered outputs one cycle later. When the increment ripples out of the top kept bit, the fraction output wraps to zero and the carry is raised. Renormalisation and exponent adjustment belong to the stage that follows.

Top module: `sig_round_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `frac_o`, `carry_o` and `inexact_o` are cleared to zero.
- R2: Outputs reflect the inputs sampled at the previous rising edge, with a latency of exactly one clock.
- R3: With `mode_i` = 2'b01 (toward zero) the output is the input with its low three bits removed, and `carry_o` is 0.
- R4: With `mode_i` = 2'b10 (toward +infinity) a positive operand (`sign_i` = 0) whose low three bits are nonzero is incremented by one unit in the last kept place. A negative operand is truncated.
- R5: With `mode_i` = 2'b11 (toward -infinity) a negative operand (`sign_i` = 1) whose low three bits are nonzero is incremented in magnitude. A positive operand is truncated.
- R6: With `mode_i` = 2'b00 (nearest, ties to even) the dropped bits `frac_i[2:0]` are compared with 3'b100. Above it the operand rounds up and below it the operand truncates. On an exact 3'b100 it rounds up only when the kept LSB `frac_i[3]` is 1.
- R7: When the increment overflows the kept field, `carry_o` is 1 and `frac_o` is all zeros.
- R8: `inexact_o` is 1 exactly when the three dropped bits were not all zero.
- R9: An input whose dropped bits are zero passes through unchanged in every mode, with `carry_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sign_i | input | 1 | Operand sign, 1 = negative |
| mode_i | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| frac_i | input | FRAC_W+3 | Fraction; bits [2:0] are the dropped positions |
| frac_o | output | FRAC_W | Rounded fraction |
| carry_o | output | 1 | Increment overflowed the fraction field |
| inexact_o | output | 1 | Dropped bits were nonzero |

## Verification
The main function is driven with the following patterns:
- Dropped-bit values just above, just below and exactly at one half. These separate a correct nearest-even decision from plain rounding-half-up and from truncation.
- Exact ties with an odd kept LSB and with an even kept LSB. These expose a tie-breaking error.
- The same nonzero tail under each directed mode with both signs. This shows whether the sign is being combined with the mode.
- An all-ones kept field. This exercises the wrap and carry.
- Exact inputs. These show that no mode ever increments without cause.

An exhaustive sweep over every fraction, sign and mode is then compared against a model built from the requirements.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_TO_ZERO   = 2'b01,
    RM_TO_POS    = 2'b10,
    RM_TO_NEG    = 2'b11
  } rnd_mode_e;

  localparam int TAIL_W = 3;
endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
(
  input  logic              sign_i,
  input  rnd_mode_e         mode_i,
  input  logic              lsb_i,
  input  logic [TAIL_W-1:0] tail_i,
  output logic              up_o
);
  logic any_tail;
  logic above_half;
  logic at_half;

  assign any_tail   = |tail_i;
  assign at_half    = (tail_i == 3'b100);
  assign above_half = tail_i[2] & (|tail_i[1:0]);

  always_comb begin
    case (mode_i)
      RM_NEAR_EVEN: up_o = above_half | (at_half & lsb_i);
      RM_TO_ZERO:   up_o = 1'b0;
      RM_TO_POS:    up_o = ~sign_i & any_tail;
      RM_TO_NEG:    up_o = sign_i & any_tail;
      default:      up_o = 1'b0;
    endcase
  end

  // an exact value must never be bumped
  always_comb begin
    if (up_o) begin
      assert_exact_no_incr_R9: assert (tail_i != '0);
    end
  end
endmodule

// File: rtl/rnd_inc.sv
module rnd_inc #(
  parameter int W = 6
) (
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] chain;

  assign chain[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_half_add
    assign sum_o[i]   = a_i[i] ^ chain[i];
    assign chain[i+1] = a_i[i] & chain[i];
  end

  assign cout_o = chain[W];

  // carry out only when every bit wrapped
  always_comb begin
    if (cout_o) begin
      assert_wrap_zero_R7: assert (sum_o == '0);
    end
  end
endmodule

// File: rtl/sig_round_unit.sv
module sig_round_unit
  import rnd_pkg::*;
#(
  parameter int FRAC_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sign_i,
  input  logic [1:0]          mode_i,
  input  logic [FRAC_W+2:0]   frac_i,
  output logic [FRAC_W-1:0]   frac_o,
  output logic                carry_o,
  output logic                inexact_o
);
  localparam int IN_W = FRAC_W + TAIL_W;

  logic [FRAC_W-1:0] kept;
  logic [TAIL_W-1:0] tail;
  logic              bump;
  logic [FRAC_W-1:0] sum;
  logic              cout;
  rnd_mode_e         mode;

  assign kept = frac_i[IN_W-1:TAIL_W];
  assign tail = frac_i[TAIL_W-1:0];
  assign mode = rnd_mode_e'(mode_i);

  rnd_decide u_decide (
    .sign_i (sign_i),
    .mode_i (mode),
    .lsb_i  (kept[0]),
    .tail_i (tail),
    .up_o   (bump)
  );

  rnd_inc #(.W(FRAC_W)) u_inc (
    .a_i    (kept),
    .cin_i  (bump),
    .sum_o  (sum),
    .cout_o (cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frac_o    <= '0;
      carry_o   <= 1'b0;
      inexact_o <= 1'b0;
    end else begin
      frac_o    <= sum;
      carry_o   <= cout;
      inexact_o <= |tail;
    end
  end

  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  assert_inexact_R8: assert property (@(posedge clk) disable iff (rst)
    primed |-> (inexact_o == ($past(frac_i[TAIL_W-1:0]) != '0)));

  assert_rtz_trunc_R3: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(mode_i) == 2'b01) |->
      (frac_o == $past(frac_i[IN_W-1:TAIL_W]) && !carry_o));

  assert_pos_neg_trunc_R4: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(mode_i) == 2'b10 && $past(sign_i)) |->
      (frac_o == $past(frac_i[IN_W-1:TAIL_W])));

  assert_neg_pos_trunc_R5: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(mode_i) == 2'b11 && !$past(sign_i)) |->
      (frac_o == $past(frac_i[IN_W-1:TAIL_W])));

  assert_carry_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    carry_o |-> (frac_o == '0 && inexact_o));

  assert_exact_pass_R9: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(frac_i[TAIL_W-1:0]) == '0) |->
      (frac_o == $past(frac_i[IN_W-1:TAIL_W]) && !carry_o));
endmodule

// File: tb/tb_sig_round_unit.sv
module tb_sig_round_unit;
  localparam int FW = 6;
  localparam int IW = FW + 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          sign_i;
  logic [1:0]    mode_i;
  logic [IW-1:0] frac_i;
  logic [FW-1:0] frac_o;
  logic          carry_o;
  logic          inexact_o;

  int n_run  = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  sig_round_unit #(.FRAC_W(FW)) dut (
    .clk(clk), .rst(rst), .sign_i(sign_i), .mode_i(mode_i),
    .frac_i(frac_i), .frac_o(frac_o), .carry_o(carry_o), .inexact_o(inexact_o)
  );

  function automatic logic [FW+1:0] model(input logic s, input logic [IW-1:0] f,
                                          input logic [1:0] m);
    logic [FW-1:0] k;
    logic [2:0]    t;
    logic          up;
    logic [FW:0]   r;
    k = f[IW-1:3];
    t = f[2:0];
    case (m)
      2'b00:   up = (t > 3'd4) || (t == 3'd4 && k[0]);
      2'b01:   up = 1'b0;
      2'b10:   up = !s && (t != 0);
      default: up = s && (t != 0);
    endcase
    r = {1'b0, k} + {{FW{1'b0}}, up};
    return {r[FW], r[FW-1:0], (t != 0)};
  endfunction

  task automatic check(input string req, input logic [FW+1:0] exp);
    logic [FW+1:0] act;
    act = {carry_o, frac_o, inexact_o};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got carry/frac/inexact %b expected %b", req, act, exp);
    end
  endtask

  task automatic apply(input logic s, input logic [IW-1:0] f, input logic [1:0] m);
    @(negedge clk);
    sign_i = s; frac_i = f; mode_i = m;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_case(input string req, input logic s, input logic [IW-1:0] f,
                          input logic [1:0] m, input logic [FW-1:0] exp_frac,
                          input logic exp_c);
    apply(s, f, m);
    check(req, {exp_c, exp_frac, (f[2:0] != 0)});
  endtask

  task automatic t_reset();
    rst = 1'b1; sign_i = 1'b0; mode_i = 2'b00; frac_i = 9'b111111111;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R1 reset", '0);
    rst = 1'b0;
  endtask

  task automatic t_latency();
    @(negedge clk);
    sign_i = 1'b0; frac_i = 9'b000101000; mode_i = 2'b01;
    @(posedge clk); @(negedge clk);
    frac_i = 9'b110000000;
    check("R2 latency first", {1'b0, 6'b000101, 1'b0});
    @(posedge clk); @(negedge clk);
    check("R2 latency second", {1'b0, 6'b110000, 1'b0});
  endtask

  task automatic t_directed();
    run_case("R4 pos up",       1'b0, 9'b100101110, 2'b10, 6'b100110, 1'b0);
    run_case("R4 neg trunc",    1'b1, 9'b100101110, 2'b10, 6'b100101, 1'b0);
    run_case("R5 neg up",       1'b1, 9'b001111001, 2'b11, 6'b010000, 1'b0);
    run_case("R5 pos trunc",    1'b0, 9'b001111001, 2'b11, 6'b001111, 1'b0);
    run_case("R3 toward zero",  1'b1, 9'b011011111, 2'b01, 6'b011011, 1'b0);
  endtask

  task automatic t_nearest();
    run_case("R6 tie odd up",    1'b0, 9'b100101100, 2'b00, 6'b100110, 1'b0);
    run_case("R6 tie even keep", 1'b1, 9'b100100100, 2'b00, 6'b100100, 1'b0);
    run_case("R6 above half",    1'b1, 9'b100100110, 2'b00, 6'b100101, 1'b0);
    run_case("R6 below half",    1'b0, 9'b100101011, 2'b00, 6'b100101, 1'b0);
  endtask

  task automatic t_carry();
    run_case("R7 carry pos",  1'b0, 9'b111111001, 2'b10, 6'b000000, 1'b1);
    run_case("R7 carry near", 1'b1, 9'b111111100, 2'b00, 6'b000000, 1'b1);
    run_case("R7 no carry rtz", 1'b0, 9'b111111111, 2'b01, 6'b111111, 1'b0);
  endtask

  task automatic t_exact();
    for (int m = 0; m < 4; m++) begin
      run_case("R9 exact R8 clear", m[0], 9'b111111000, m[1:0], 6'b111111, 1'b0);
    end
  endtask

  task automatic t_sweep();
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int f = 0; f < (1 << IW); f++) begin
          apply(s[0], f[IW-1:0], m[1:0]);
          check("R3-R8 sweep R6 R8", model(s[0], f[IW-1:0], m[1:0]));
        end
      end
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_directed();
    t_nearest();
    t_carry();
    t_exact();
    t_sweep();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule